// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Receiver

This block recovers characters from a single non-return-to-zero serial line. A free-running 16x oversampling strobe (`os_tick`) paces it. The line idles at 1. A falling edge marks a possible start bit. Each later bit is taken once, near its centre, and the data arrives least significant bit first.

A four-bit format code sets the frame. It selects 8 data bits, 7 data bits, 8 data bits with an odd-parity or even-parity ninth bit, or 8 data bits with a ninth bit that marks an address. Two further controls set the stop-bit count and invert the line polarity.

Finished characters are stored in a two-entry queue and leave through a valid/ready port. Each character carries its data, its ninth bit, a parity error flag and a framing error flag. Back-pressure rules for the port:
- While `out_valid` is high and `out_ready` is low, the head character is held unchanged.
- A character is removed on a cycle where both `out_valid` and `out_ready` are high.
- The receiver never waits for the consumer. If a character completes when no queue entry is free, it is dropped and a sticky overrun flag is raised.

Top module: `nrz_rx_multi`

## Requirements
- R1: After reset, `out_valid` is 0 and `overrun` is 0.
- R2: Format code 0000 receives 8 data bits, least significant bit first, taken at the 8th oversample tick of each bit; `out_bit9` and `out_perr` are 0.
- R3: Format code 0001 receives 7 data bits; `out_data[7]` is delivered as 0.
- R4: Format codes 0011 (even) and 0010 (odd) receive a ninth bit and present it on `out_bit9`. `out_perr` is 1 when the count of ones among the 8 data bits and the ninth bit does not match the selected parity. In all other codes `out_perr` is 0.
- R5: Format code 0100 receives a ninth bit and presents it on `out_bit9` as an address marker (1 = address, 0 = data), with `out_perr` 0.
- R6: `out_ferr` is 1 when any checked stop bit is sampled as 0. With `two_stop` = 1, both stop bits are checked.
- R7: The queue holds two characters. A character that completes while both entries are full, and no entry is read in that cycle, is discarded and sets `overrun`. `overrun` stays at 1 until `ovr_clr` is pulsed.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and the outputs hold. A character is removed when `out_valid` and `out_ready` are both 1, and characters leave in arrival order.
- R9: With `invert` = 1, the line is complemented before any decoding, so it idles at 0.
- R10: A low pulse on the line that has ended by the start-bit centre sample is ignored, and no character is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| fmt | input | 4 | Frame format code |
| two_stop | input | 1 | 1 = check two stop bits |
| invert | input | 1 | 1 = line polarity inverted |
| line_in | input | 1 | Serial input line |
| ovr_clr | input | 1 | Pulse to clear the overrun flag |
| out_valid | output | 1 | Head character available |
| out_ready | input | 1 | Consumer accepts the head character |
| out_data | output | 8 | Received data, 7-bit characters zero-extended |
| out_bit9 | output | 1 | Received ninth bit, 0 when the format has none |
| out_perr | output | 1 | Parity mismatch for this character |
| out_ferr | output | 1 | Stop bit received as 0 for this character |
| overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the queue never holds more than two entries;
- the head is held steady while stalled;
- a dropped character always raises `overrun`, and the flag stays set until it is cleared;
- the bit index stays inside the selected frame;
- no parity error appears outside the parity formats.

The bench's scenarios are needed for everything that depends on the bit values themselves. That covers bit order, 7-bit zero extension, the even and odd parity results, the address marker, framing errors on either stop bit, inverted polarity, rejection of short start glitches, and which character is lost on overrun.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;
  localparam logic [3:0] FMT_8B   = 4'b0000;
  localparam logic [3:0] FMT_7B   = 4'b0001;
  localparam logic [3:0] FMT_ODD  = 4'b0010;
  localparam logic [3:0] FMT_EVEN = 4'b0011;
  localparam logic [3:0] FMT_ADDR = 4'b0100;

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       perr;
    logic       ferr;
  } rx_char_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_STOP} rx_state_e;
endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  output logic line
);
  logic [STAGES-1:0] sr;

  // polarity applied ahead of the synchroniser so a polarity change
  // together with the new idle level produces no false edge
  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], raw ^ invert};
  end

  assign line = sr[STAGES-1];
endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import nrz_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [3:0] fmt,
  input  logic       two_stop,
  output logic       push,
  output rx_char_t   push_char
);
  localparam int CW     = $clog2(OSR);
  localparam int MID    = OSR / 2;
  localparam int NB_MAX = DATA_W + 1;
  localparam int IW     = $clog2(NB_MAX + 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [NB_MAX-1:0] bits;
  logic              stop_idx;
  logic              ferr_acc;
  logic              ferr_q;
  logic              ferr_now;

  logic          ninth;
  logic [IW-1:0] nbits;

  always_comb begin
    ninth = (fmt == FMT_ODD) || (fmt == FMT_EVEN) || (fmt == FMT_ADDR);
    if (fmt == FMT_7B)  nbits = IW'(DATA_W - 1);
    else if (ninth)     nbits = IW'(DATA_W + 1);
    else                nbits = IW'(DATA_W);
    ferr_now = ferr_acc | ~line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      bits     <= '0;
      stop_idx <= 1'b0;
      ferr_acc <= 1'b0;
      ferr_q   <= 1'b0;
      push     <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: if (!line) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: if (cnt == CW'(MID - 1)) begin
            cnt  <= '0;
            idx  <= '0;
            bits <= '0;
            state <= line ? ST_IDLE : ST_BITS;
          end else cnt <= cnt + 1'b1;
          ST_BITS: if (cnt == CW'(OSR - 1)) begin
            cnt       <= '0;
            bits[idx] <= line;
            if (idx == nbits - 1'b1) begin
              state    <= ST_STOP;
              stop_idx <= 1'b0;
              ferr_acc <= 1'b0;
            end else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            if (two_stop && !stop_idx) begin
              stop_idx <= 1'b1;
              ferr_acc <= ferr_now;
            end else begin
              push   <= 1'b1;
              ferr_q <= ferr_now;
              state  <= ST_IDLE;
            end
          end else cnt <= cnt + 1'b1;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    push_char.data = (fmt == FMT_7B) ? {1'b0, bits[DATA_W-2:0]} : bits[DATA_W-1:0];
    push_char.bit9 = ninth ? bits[DATA_W] : 1'b0;
    unique case (fmt)
      FMT_EVEN: push_char.perr =  (^bits);
      FMT_ODD:  push_char.perr = ~(^bits);
      default:  push_char.perr = 1'b0;
    endcase
    push_char.ferr = ferr_q;
  end

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BITS) |-> (idx < nbits)); // R2
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push); // R2
  AST_PERR_PARITY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fmt != FMT_ODD && fmt != FMT_EVEN) |-> !push_char.perr); // R4
endmodule

// File: rtl/rx_char_q.sv
module rx_char_q
  import nrz_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t wdata,
  output logic     valid,
  input  logic     ready,
  output rx_char_t rdata,
  input  logic     ovr_clr,
  output logic     overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  rx_char_t      mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] count;
  logic          pop, accept;

  assign valid  = (count != '0);
  assign rdata  = mem[rp];
  assign pop    = valid && ready;
  assign accept = push && ((count < NW'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (accept) begin
        mem[wp] <= wdata;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + NW'(accept) - NW'(pop);
      if (push && !accept) overrun <= 1'b1;
      else if (ovr_clr)    overrun <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH)); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == NW'(DEPTH) && !ready) |=> overrun); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(rdata))); // R8
endmodule

// File: rtl/nrz_rx_multi.sv
module nrz_rx_multi
  import nrz_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [3:0] fmt,
  input  logic       two_stop,
  input  logic       invert,
  input  logic       line_in,
  input  logic       ovr_clr,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_bit9,
  output logic       out_perr,
  output logic       out_ferr,
  output logic       overrun
);
  logic     line;
  logic     push;
  rx_char_t push_char;
  rx_char_t head;

  rx_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(line_in), .invert(invert), .line(line)
  );

  rx_deser #(.OSR(OSR), .DATA_W(8)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .fmt(fmt),
    .two_stop(two_stop), .push(push), .push_char(push_char)
  );

  rx_char_q #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_char),
    .valid(out_valid), .ready(out_ready), .rdata(head),
    .ovr_clr(ovr_clr), .overrun(overrun)
  );

  assign out_data = head.data;
  assign out_bit9 = head.bit9;
  assign out_perr = head.perr;
  assign out_ferr = head.ferr;
endmodule

// File: tb/tb_nrz_rx_multi.sv
module tb_nrz_rx_multi;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 0, rst_n = 0, os_tick = 0;
  logic [3:0] fmt = 4'b0000;
  logic two_stop = 0, invert = 0, line_in = 1, ovr_clr = 0, out_ready = 0;
  logic out_valid, out_bit9, out_perr, out_ferr, overrun;
  logic [7:0] out_data;
  int errors = 0, checks = 0, tc = 0;
  logic inv = 0;
  logic done = 0;

  nrz_rx_multi dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .fmt(fmt), .two_stop(two_stop),
    .invert(invert), .line_in(line_in), .ovr_clr(ovr_clr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_bit9(out_bit9),
    .out_perr(out_perr), .out_ferr(out_ferr), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tc = (tc == TDIV - 1) ? 0 : tc + 1;
    os_tick <= (tc == 0);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    line_in = v ^ inv;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] b, input int nb, input logic s0, input logic s1, input int ns);
    drive(1'b0);
    for (int i = 0; i < nb; i++) drive(b[i]);
    drive(s0);
    if (ns == 2) drive(s1);
    drive(1'b1);
  endtask

  task automatic expect_char(input logic [7:0] d, input logic b9, input logic pe, input logic fe, input string tag);
    int w = 0;
    while (!out_valid && w < 4000) begin @(negedge clk); w++; end
    check(out_valid, {tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({out_data, out_bit9, out_perr, out_ferr} == {d, b9, pe, fe}, tag,
          {21'b0, out_data, out_bit9, out_perr, out_ferr}, {21'b0, d, b9, pe, fe});
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic t_reset();
    check(out_valid == 0, "R1 valid after reset", {31'b0, out_valid}, 0);
    check(overrun == 0, "R1 overrun after reset", {31'b0, overrun}, 0);
  endtask

  task automatic t_8bit();
    fmt = 4'b0000;
    send_frame(9'h0A5, 8, 1, 1, 1); expect_char(8'hA5, 0, 0, 0, "R2 8bit A5");
    send_frame(9'h03C, 8, 1, 1, 1); expect_char(8'h3C, 0, 0, 0, "R2 8bit 3C");
  endtask

  task automatic t_7bit();
    fmt = 4'b0001;
    send_frame(9'h055, 7, 1, 1, 1); expect_char(8'h55, 0, 0, 0, "R3 7bit 55");
    send_frame(9'h07F, 7, 1, 1, 1); expect_char(8'h7F, 0, 0, 0, "R3 7bit 7F zero-ext");
  endtask

  task automatic t_parity();
    fmt = 4'b0011;
    send_frame(9'h0A5, 9, 1, 1, 1); expect_char(8'hA5, 0, 0, 0, "R4 even ok");
    send_frame(9'h1A5, 9, 1, 1, 1); expect_char(8'hA5, 1, 1, 0, "R4 even bad");
    fmt = 4'b0010;
    send_frame(9'h1A5, 9, 1, 1, 1); expect_char(8'hA5, 1, 0, 0, "R4 odd ok");
    send_frame(9'h0A5, 9, 1, 1, 1); expect_char(8'hA5, 0, 1, 0, "R4 odd bad");
  endtask

  task automatic t_addr();
    fmt = 4'b0100;
    send_frame(9'h112, 9, 1, 1, 1); expect_char(8'h12, 1, 0, 0, "R5 address");
    send_frame(9'h034, 9, 1, 1, 1); expect_char(8'h34, 0, 0, 0, "R5 data");
  endtask

  task automatic t_frame();
    fmt = 4'b0000;
    send_frame(9'h081, 8, 0, 1, 1); expect_char(8'h81, 0, 0, 1, "R6 stop low");
    two_stop = 1;
    send_frame(9'h042, 8, 1, 0, 2); expect_char(8'h42, 0, 0, 1, "R6 second stop low");
    send_frame(9'h024, 8, 1, 1, 2); expect_char(8'h24, 0, 0, 0, "R6 two stops ok");
    two_stop = 0;
  endtask

  task automatic t_overrun_stall();
    logic [7:0] snap;
    fmt = 4'b0000;
    send_frame(9'h011, 8, 1, 1, 1);
    send_frame(9'h022, 8, 1, 1, 1);
    snap = out_data;
    repeat (30) @(negedge clk);
    check(out_valid == 1, "R8 valid held", {31'b0, out_valid}, 1);
    check(out_data == snap && snap == 8'h11, "R8 head stable", {24'b0, out_data}, 32'h11);
    check(overrun == 0, "R7 no overrun at two", {31'b0, overrun}, 0);
    send_frame(9'h033, 8, 1, 1, 1);
    check(overrun == 1, "R7 overrun set", {31'b0, overrun}, 1);
    expect_char(8'h11, 0, 0, 0, "R8 order first");
    expect_char(8'h22, 0, 0, 0, "R8 order second");
    @(negedge clk);
    check(out_valid == 0, "R7 third dropped", {31'b0, out_valid}, 0);
    repeat (20) @(negedge clk);
    check(overrun == 1, "R7 overrun sticky", {31'b0, overrun}, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0; @(negedge clk);
    check(overrun == 0, "R7 overrun cleared", {31'b0, overrun}, 0);
  endtask

  task automatic t_invert();
    @(negedge clk);
    inv = 1; invert = 1; line_in = 0;
    repeat (2 * BITC) @(negedge clk);
    check(out_valid == 0, "R9 no spurious char", {31'b0, out_valid}, 0);
    send_frame(9'h0C3, 8, 1, 1, 1); expect_char(8'hC3, 0, 0, 0, "R9 inverted C3");
    @(negedge clk);
    inv = 0; invert = 0; line_in = 1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic t_glitch();
    @(negedge clk); line_in = 0;
    repeat (2 * TDIV) @(negedge clk);
    line_in = 1;
    repeat (3 * BITC) @(negedge clk);
    check(out_valid == 0, "R10 glitch ignored", {31'b0, out_valid}, 0);
    send_frame(9'h05A, 8, 1, 1, 1); expect_char(8'h5A, 0, 0, 0, "R10 next char ok");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_8bit();
    t_7bit();
    t_parity();
    t_addr();
    t_frame();
    t_overrun_stall();
    t_invert();
    t_glitch();
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule